// File: doc/BRIEF.md
# Statechart Transition Set Selector

This block decides which transitions of a hierarchical state machine fire together in one microstep. It holds a fixed chart description as parameters: for every transition, the index of its source state, a mask of the event lines it responds to, a flag marking it as eventless, and a row of a conflict matrix. At run time it receives the vector of currently active states, a one-hot event vector and a phase flag. It returns a vector with one bit per transition, set for each transition chosen for firing.

Selection is a strict priority chain. Transitions are numbered in post-order of the chart tree, and a lower number wins. A transition that is otherwise eligible is dropped if a lower-numbered transition that conflicts with it has already been chosen. Eventless transitions are considered only in the spontaneous phase. Event-driven transitions are considered only outside it.

The selection logic is combinational. A thin registered shell captures the inputs on one clock edge and the resulting selection on the next, so each stage can be observed at a register boundary.

Top module: `tsel_top`

## Requirements
- R1: A transition is never selected unless the state given as its source is set in the sampled active-state vector.
- R2: A transition with event lines in its mask is selected only when the sampled phase flag is 0 (event phase) and at least one sampled event line set in its mask is high.
- R3: An eventless transition is selected only when the sampled phase flag is 1 (spontaneous phase), and it then needs no event line at all.
- R4: Event line k is bit k of `event_i`. A transition whose mask has all bits set acts as a wildcard and responds to every event line.
- R5: A transition is blocked when a lower-indexed transition that conflicts with it is selected in the same step. Conflict entry (i, j) is bit i*T+j of the conflict parameter.
- R6: Only conflict entries with j < i take effect. Entries on or above the diagonal never block a transition.
- R7: With the phase flag 0 and no event line high, the selection is all zeros.
- R8: Inputs are sampled on one rising edge and the selection for them appears on `sel_o` after the following rising edge. An active-low reset clears both stages, so `sel_o` reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_i | input | S | Active-state vector, bit n set when state n is active |
| event_i | input | E | One-hot event lines, all zero when no event is present |
| spont_i | input | 1 | Phase flag: 1 selects the eventless phase, 0 the event phase |
| sel_o | output | T | Registered selection, bit i set when transition i fires |

## Verification
The hardest situation to reach is a transition that is fully eligible but blocked only because a lower-indexed conflicting transition was picked in the same step. In the default chart, two event transitions from sibling states both listen to event 0, and a wildcard transition sits on a third state. The bench activates chosen combinations of those states, so that each transition alone, each pair and the full trio compete. It then repeats this in the spontaneous phase with the two conflicting eventless transitions, where the upper-triangle entry for that pair is set on purpose to expose any use of it.

// File: rtl/tsel_pkg.sv
`timescale 1ns/1ps
package tsel_pkg;

    // Phase of the microstep being evaluated.
    typedef enum logic {
        PH_EVENT = 1'b0,
        PH_SPONT = 1'b1
    } phase_e;

    // Width needed to hold an index in [0, n-1], at least one bit.
    function automatic int idx_w(input int n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/tsel_enable.sv
`timescale 1ns/1ps
// Per-transition eligibility: source active, phase matches, event matches.
module tsel_enable #(
    parameter int T  = 6,
    parameter int S  = 5,
    parameter int E  = 4,
    parameter int SW = 3,
    parameter logic [T*SW-1:0] P_SRC       = '0,
    parameter logic [T*E-1:0]  P_EVMASK    = '0,
    parameter logic [T-1:0]    P_EVENTLESS = '0
) (
    input  logic [S-1:0]     active,
    input  logic [E-1:0]     evt,
    input  tsel_pkg::phase_e phase,
    output logic [T-1:0]     elig
);
    import tsel_pkg::*;

    for (genvar i = 0; i < T; i++) begin : g_tr
        localparam int unsigned SRC = int'(P_SRC[i*SW +: SW]);
        localparam logic [E-1:0] MASK = P_EVMASK[i*E +: E];

        logic src_on;
        assign src_on = active[SRC];

        if (P_EVENTLESS[i]) begin : g_eventless
            // Event term is constant true; only the spontaneous phase admits it.
            assign elig[i] = src_on && (phase == PH_SPONT);
        end else begin : g_evented
            logic hit;
            assign hit     = |(evt & MASK);
            assign elig[i] = src_on && (phase == PH_EVENT) && hit;
        end
    end

endmodule

// File: rtl/tsel_chain.sv
`timescale 1ns/1ps
// Unrolled priority chain: transition i is dropped when a lower-indexed,
// conflicting transition has been chosen.
module tsel_chain #(
    parameter int T = 6,
    parameter logic [T*T-1:0] P_CONFLICT = '0
) (
    input  logic [T-1:0] elig,
    output logic [T-1:0] sel
);

    always_comb begin
        logic [T-1:0] pick;
        pick = '0;
        for (int i = 0; i < T; i++) begin
            logic blocked;
            blocked = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (P_CONFLICT[i*T + j] && pick[j]) begin
                    blocked = 1'b1;
                end
            end
            pick[i] = elig[i] && !blocked;
        end
        sel = pick;
    end

endmodule

// File: rtl/tsel_top.sv
`timescale 1ns/1ps
// Registered shell around the selector: inputs captured, then selection.
module tsel_top #(
    parameter int T  = 6,
    parameter int S  = 5,
    parameter int E  = 4,
    parameter int SW = tsel_pkg::idx_w(S),
    // source state per transition, field i at [i*SW +: SW]
    parameter logic [T*SW-1:0] P_SRC       = 18'h14611,
    // event-line mask per transition, field i at [i*E +: E]
    parameter logic [T*E-1:0]  P_EVMASK    = 24'h400F31,
    parameter logic [T-1:0]    P_EVENTLESS = 6'b011000,
    // entry (i, j) at bit i*T+j
    parameter logic [T*T-1:0]  P_CONFLICT  = 36'h0_0840_3146
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [S-1:0] active_i,
    input  logic [E-1:0] event_i,
    input  logic         spont_i,
    output logic [T-1:0] sel_o
);
    import tsel_pkg::*;

    typedef struct packed {
        logic [S-1:0] act;
        logic [E-1:0] ev;
        phase_e       ph;
        logic [T-1:0] sel;
    } state_t;

    state_t st_d, st_q;

    logic [S-1:0] act_q;
    logic [E-1:0] ev_q;
    phase_e       ph_q;
    logic [T-1:0] elig_w;
    logic [T-1:0] sel_w;

    assign act_q = st_q.act;
    assign ev_q  = st_q.ev;
    assign ph_q  = st_q.ph;

    tsel_enable #(
        .T(T), .S(S), .E(E), .SW(SW),
        .P_SRC(P_SRC), .P_EVMASK(P_EVMASK), .P_EVENTLESS(P_EVENTLESS)
    ) u_enable (
        .active (act_q),
        .evt    (ev_q),
        .phase  (ph_q),
        .elig   (elig_w)
    );

    tsel_chain #(
        .T(T), .P_CONFLICT(P_CONFLICT)
    ) u_chain (
        .elig (elig_w),
        .sel  (sel_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.act = active_i;
        st_d.ev  = event_i;
        st_d.ph  = spont_i ? PH_SPONT : PH_EVENT;
        st_d.sel = sel_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_o = st_q.sel;

endmodule

// File: rtl/tsel_chk.sv
`timescale 1ns/1ps
// Properties of the selector, attached to tsel_top by bind.
module tsel_chk #(
    parameter int T  = 6,
    parameter int S  = 5,
    parameter int E  = 4,
    parameter int SW = 3,
    parameter logic [T*SW-1:0] P_SRC       = '0,
    parameter logic [T*E-1:0]  P_EVMASK    = '0,
    parameter logic [T-1:0]    P_EVENTLESS = '0,
    parameter logic [T*T-1:0]  P_CONFLICT  = '0
) (
    input logic         clk,
    input logic         rst_n,
    input logic [S-1:0] act_q,
    input logic [E-1:0] ev_q,
    input logic         ph_q,
    input logic [T-1:0] sel_o
);

    // R8: reset leaves the output cleared
    p_reset_clear_r8: assert property (@(posedge clk) !rst_n |=> sel_o == '0);

    // R2: event transitions stay silent in the spontaneous phase
    p_no_event_in_spont_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q |=> (sel_o & ~P_EVENTLESS) == '0);

    // R3: eventless transitions stay silent in the event phase
    p_no_eventless_in_event_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_q |=> (sel_o & P_EVENTLESS) == '0);

    // R7: idle event phase gives nothing
    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ph_q && ev_q == '0) |=> sel_o == '0);

    for (genvar i = 0; i < T; i++) begin : g_tr
        localparam int unsigned SRC = int'(P_SRC[i*SW +: SW]);
        localparam logic [E-1:0] MASK = P_EVMASK[i*E +: E];

        // R1: inactive source forbids the transition
        p_src_active_r1: assert property (@(posedge clk) disable iff (!rst_n)
            !act_q[SRC] |=> !sel_o[i]);

        if (!P_EVENTLESS[i]) begin : g_ev
            // R4: no matching event line, no selection
            p_evmatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
                ((ev_q & MASK) == '0) |=> !sel_o[i]);
        end

        for (genvar j = 0; j < i; j++) begin : g_pair
            if (P_CONFLICT[i*T + j]) begin : g_cf
                // R5: a conflicting pair never fires together
                p_conflict_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
                    !(sel_o[i] && sel_o[j]));
            end
        end
    end

endmodule

bind tsel_top tsel_chk #(
    .T(T), .S(S), .E(E), .SW(SW),
    .P_SRC(P_SRC), .P_EVMASK(P_EVMASK),
    .P_EVENTLESS(P_EVENTLESS), .P_CONFLICT(P_CONFLICT)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .act_q (act_q),
    .ev_q  (ev_q),
    .ph_q  (ph_q),
    .sel_o (sel_o)
);

// File: tb/tsel_top_tb.sv
`timescale 1ns/1ps
// Default chart used by the checks below:
//   t0: src 1, event 0            t1: src 2, events 0|1, conflicts t0
//   t2: src 0, wildcard, conflicts t0,t1
//   t3: src 3, eventless          t4: src 4, eventless, conflicts t3
//   t5: src 2, event 2
//   upper-triangle entries (0,1),(0,2),(1,2),(3,4) are also set.
module tsel_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] active_i = '0;
    logic [3:0] event_i = '0;
    logic       spont_i = 1'b0;
    logic [5:0] sel_o;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tsel_top u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (active_i),
        .event_i  (event_i),
        .spont_i  (spont_i),
        .sel_o    (sel_o)
    );

    task automatic check(input logic [5:0] exp, input string req);
        checks++;
        if (sel_o !== exp) begin
            errors++;
            $display("FAIL %s sel_o=%b expected=%b", req, sel_o, exp);
        end
    endtask

    // Drive at a falling edge, let two rising edges pass, sample.
    task automatic step(input logic [4:0] act, input logic [3:0] ev, input logic sp,
                        input logic [5:0] exp, input string req);
        @(negedge clk);
        active_i = act; event_i = ev; spont_i = sp;
        @(negedge clk);
        @(negedge clk);
        check(exp, req);
    endtask

    task automatic t_reset;
        active_i = 5'b11111; event_i = 4'b0001; spont_i = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(6'b000000, "R8 reset");
        @(negedge clk);
        rst_n = 1'b1;
        active_i = '0; event_i = '0;
        @(negedge clk);
        check(6'b000000, "R8 after release");
    endtask

    task automatic t_latency;
        step(5'b00000, 4'b0000, 1'b0, 6'b000000, "R8 idle");
        @(negedge clk);
        active_i = 5'b00010; event_i = 4'b0001; spont_i = 1'b0;
        @(negedge clk);
        check(6'b000000, "R8 one edge not yet");
        @(negedge clk);
        check(6'b000001, "R8 two edges");
    endtask

    task automatic t_source;
        step(5'b00010, 4'b1000, 1'b0, 6'b000000, "R1 wildcard source off");
        step(5'b00001, 4'b1000, 1'b0, 6'b000100, "R1 wildcard source on");
        step(5'b00000, 4'b0001, 1'b0, 6'b000000, "R1 no state active");
    endtask

    task automatic t_events;
        step(5'b00100, 4'b0001, 1'b0, 6'b000010, "R2 t1 on event 0");
        step(5'b00100, 4'b0010, 1'b0, 6'b000010, "R2 t1 on event 1");
        step(5'b00100, 4'b1000, 1'b0, 6'b000000, "R2 event outside mask");
        step(5'b00101, 4'b0100, 1'b0, 6'b100100, "R4 wildcard with t5");
        step(5'b11111, 4'b0001, 1'b1, 6'b001000, "R2 event ignored in spont phase");
    endtask

    task automatic t_eventless;
        step(5'b10000, 4'b0000, 1'b1, 6'b010000, "R3 t4 alone");
        step(5'b11000, 4'b0001, 1'b0, 6'b000000, "R3 eventless idle in event phase");
    endtask

    task automatic t_priority;
        step(5'b00110, 4'b0001, 1'b0, 6'b000001, "R5 t0 beats t1");
        step(5'b00111, 4'b0001, 1'b0, 6'b000001, "R5 t0 beats t1 and t2");
        step(5'b00101, 4'b0001, 1'b0, 6'b000010, "R5 t1 beats t2");
        step(5'b00101, 4'b0100, 1'b0, 6'b100100, "R5 non-conflicting pair both fire");
    endtask

    task automatic t_upper;
        // (3,4) is set above the diagonal: t3 must still win over t4
        step(5'b11000, 4'b0000, 1'b1, 6'b001000, "R6 upper entry unused");
        // (0,1),(0,2) set: t0 alone still fires
        step(5'b00011, 4'b0001, 1'b0, 6'b000001, "R6 t0 not blocked by higher");
    endtask

    task automatic t_idle;
        step(5'b11111, 4'b0000, 1'b0, 6'b000000, "R7 no event all active");
        step(5'b00110, 4'b0000, 1'b0, 6'b000000, "R7 no event partial");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R8 run did not complete, sel_o=%b expected=done", sel_o);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset;
        t_latency;
        t_source;
        t_events;
        t_eventless;
        t_priority;
        t_upper;
        t_idle;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule